// File: doc/BRIEF.md
# Byte/Word Load-Store Unit with Stack Addressing

This unit carries out one memory command at a time for a 16-bit processor. The processor supplies a command: load or store, an addressing form, an immediate slot index, a signed offset, an access size, a stack flag, the store data and the relevant register values. The unit then forms the effective address and drives a byte-wide memory port. A 16-bit word moves as two little-endian byte transfers, and a byte moves as one.

Loads return their result through a register write strobe. The extended form can also update its base register as a stack pointer:
- A stack load lowers the base by the access size before it forms the address.
- A stack store forms the address from the current base and raises the base by the access size once the data is written.

Decode, register file and ALU are outside the block. The memory read path is combinational: read data is valid in the same cycle as the address.

Top module: `ldst_unit`

## Requirements
- R1: In fixed-slot mode (`mode_i`=2'b00) the address is `slot_i` times two and the access is a word, whatever `size_word_i` says.
- R2: In register mode (`mode_i`=2'b01) the address is `ind_i` and the access is a word.
- R3: In extended mode (`mode_i`=2'b10, or 2'b11) the address is `base_i` plus `off_i` read as a signed two's-complement value. The access is a word when `size_word_i`=1 and a byte when it is 0.
- R4: Stack load (extended mode, `stack_i`=1, `store_i`=0):
  - the base is reduced by the size (1 or 2) first, and the address is formed from the reduced base;
  - `base_we_o` pulses in the first transfer cycle, with the reduced base on `base_wdata_o`.
- R5: Stack store (extended mode, `stack_i`=1, `store_i`=1):
  - the address is formed from the unmodified base;
  - `base_we_o` pulses in the done cycle, with base plus size on `base_wdata_o`.
- R6: A word access is little-endian. The first transfer carries the low byte at the address. The next cycle carries the high byte at the address plus one, and that address wraps at 16 bits.
- R7: A byte access uses exactly one transfer. A byte load places the read byte in bits 7:0 of `ld_data_o` with bits 15:8 zero. A byte store writes bits 7:0 of `sdata_i`.
- R8: The first transfer happens in the cycle after the command is accepted. `done_o` is high for exactly one cycle, the cycle after the last transfer. For loads, `ld_we_o` and the result are valid in that same cycle.
- R9: Base register updates wrap modulo 2^16.
- R10: Non-stack commands never assert `base_we_o`. Stores never assert `ld_we_o`. Only stores assert `mem_we_o`, and only loads assert `mem_re_o`.
- R11: A command is accepted only when the unit is idle or in its done cycle. A `start_i` pulse during a transfer is ignored and does not disturb the command in progress.
- R12: While reset is held, all strobes (`mem_re_o`, `mem_we_o`, `base_we_o`, `ld_we_o`, `done_o`) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| store_i | input | 1 | 1 = store, 0 = load |
| mode_i | input | 2 | Addressing form: 00 fixed slot, 01 register, 1x extended |
| slot_i | input | IMM_W | Fixed-mode word slot index |
| off_i | input | OFF_W | Extended-mode signed offset |
| size_word_i | input | 1 | Extended-mode size: 1 word, 0 byte |
| stack_i | input | 1 | Extended-mode stack flag |
| sdata_i | input | DW | Store data register value |
| ind_i | input | AW | Register-mode address register value |
| base_i | input | AW | Base register read value |
| base_we_o | output | 1 | Base register write strobe |
| base_wdata_o | output | AW | Updated base value |
| mem_addr_o | output | AW | Byte address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | BW | Byte to write |
| mem_rdata_i | input | BW | Byte read (combinational) |
| ld_we_o | output | 1 | Load result write strobe |
| ld_data_o | output | DW | Load result |
| done_o | output | 1 | Command complete pulse |

## Verification
The bench sweeps every combination of the following:
- load and store;
- the three addressing forms;
- both sizes;
- the stack flag on and off;
- base, offset and slot values at the ends of the 16-bit range (0x0000, 0x0001, 0xFFFF, 0x8000, and offsets of 0, +1, -1, +31 and -32).

The memory model returns a byte that is a function of the address. Because of that, a swapped byte order, a missing wrap on the second address, or a lost zero-extension all show up as a wrong load value. Stack cases whose base sits at the range edges separate pre-decrement from post-increment and test the modulo-2^16 wrap. Every other command carries a stray `start_i` in its first transfer cycle, which would expose a recapture while busy.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam logic [1:0] AM_FIXED = 2'b00;
  localparam logic [1:0] AM_REG   = 2'b01;
  localparam logic [1:0] AM_EXT   = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_DONE = 2'd3
  } lsu_state_e;
endpackage

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IMM_W = 8,
  parameter int OFF_W = 6
) (
  input  logic [1:0]       mode_i,
  input  logic [IMM_W-1:0] slot_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             size_word_i,
  input  logic             stack_i,
  input  logic             store_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    ind_i,
  output logic             word_o,
  output logic [AW-1:0]    addr_o,
  output logic             base_upd_o,
  output logic [AW-1:0]    base_next_o
);
  localparam int EXT_W = AW - OFF_W;

  logic          ext;
  logic [AW-1:0] sz, off_x, slot_x, base_dec, base_inc, ea_base;

  assign ext      = (mode_i != AM_FIXED) && (mode_i != AM_REG);
  assign word_o   = !ext || size_word_i;
  assign sz       = word_o ? AW'(2) : AW'(1);
  assign base_dec = base_i - sz;
  assign base_inc = base_i + sz;
  assign off_x    = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign slot_x   = AW'(slot_i) << 1;
  // stack load addresses from the already-decremented base
  assign ea_base  = (stack_i && !store_i) ? base_dec : base_i;

  always_comb begin
    unique case (mode_i)
      AM_FIXED: addr_o = slot_x;
      AM_REG:   addr_o = ind_i;
      default:  addr_o = ea_base + off_x;
    endcase
  end

  assign base_upd_o  = ext && stack_i;
  assign base_next_o = store_i ? base_inc : base_dec;
endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic word_i,
  output logic cap_o,
  output logic lo_o,
  output logic hi_o,
  output logic done_o
);
  lsu_state_e state_q, state_d;

  assign cap_o = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LO;
      ST_LO:   state_d = word_i ? ST_HI : ST_DONE;
      ST_HI:   state_d = ST_DONE;
      ST_DONE: state_d = start_i ? ST_LO : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign lo_o   = (state_q == ST_LO);
  assign hi_o   = (state_q == ST_HI);
  assign done_o = (state_q == ST_DONE);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_hi_after_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_o |-> $past(lo_o));
  a_r8_done_after_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(lo_o) || $past(hi_o)));
endmodule

// File: rtl/ldst_bytes.sv
module ldst_bytes #(
  parameter int DW = 16,
  parameter int BW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          lo_rd_i,
  input  logic          hi_rd_i,
  input  logic          hi_i,
  input  logic [BW-1:0] rdata_i,
  input  logic [DW-1:0] sdata_i,
  output logic [BW-1:0] wdata_o,
  output logic [DW-1:0] ld_data_o
);
  logic [DW-1:0] ld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q <= '0;
    end else if (clr_i) begin
      ld_q <= '0;
    end else begin
      if (lo_rd_i) ld_q[BW-1:0]    <= rdata_i;
      if (hi_rd_i) ld_q[DW-1:BW]   <= rdata_i;
    end
  end

  assign wdata_o   = hi_i ? sdata_i[DW-1:BW] : sdata_i[BW-1:0];
  assign ld_data_o = ld_q;

  a_r6_lo_lane_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_rd_i && !clr_i) |=> ld_data_o[BW-1:0] == $past(ld_data_o[BW-1:0]));
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int IMM_W = 8,
  parameter int OFF_W = 6,
  parameter int BW    = DW / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             store_i,
  input  logic [1:0]       mode_i,
  input  logic [IMM_W-1:0] slot_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             size_word_i,
  input  logic             stack_i,
  input  logic [DW-1:0]    sdata_i,
  input  logic [AW-1:0]    ind_i,
  input  logic [AW-1:0]    base_i,
  output logic             base_we_o,
  output logic [AW-1:0]    base_wdata_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic [BW-1:0]    mem_wdata_o,
  input  logic [BW-1:0]    mem_rdata_i,
  output logic             ld_we_o,
  output logic [DW-1:0]    ld_data_o,
  output logic             done_o
);
  logic             cap, lo, hi, done, xfer;
  logic             store_q, size_q, stack_q;
  logic [1:0]       mode_q;
  logic [IMM_W-1:0] slot_q;
  logic [OFF_W-1:0] off_q;
  logic [DW-1:0]    sdata_q;
  logic [AW-1:0]    ind_q, base_q;
  logic             word, base_upd;
  logic [AW-1:0]    ea, base_next;

  // command is latched so callers may change fields while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= 1'b0;
      mode_q  <= AM_FIXED;
      slot_q  <= '0;
      off_q   <= '0;
      size_q  <= 1'b0;
      stack_q <= 1'b0;
      sdata_q <= '0;
      ind_q   <= '0;
      base_q  <= '0;
    end else if (cap) begin
      store_q <= store_i;
      mode_q  <= mode_i;
      slot_q  <= slot_i;
      off_q   <= off_i;
      size_q  <= size_word_i;
      stack_q <= stack_i;
      sdata_q <= sdata_i;
      ind_q   <= ind_i;
      base_q  <= base_i;
    end
  end

  ldst_agen #(.AW(AW), .IMM_W(IMM_W), .OFF_W(OFF_W)) agen_i (
    .mode_i     (mode_q),
    .slot_i     (slot_q),
    .off_i      (off_q),
    .size_word_i(size_q),
    .stack_i    (stack_q),
    .store_i    (store_q),
    .base_i     (base_q),
    .ind_i      (ind_q),
    .word_o     (word),
    .addr_o     (ea),
    .base_upd_o (base_upd),
    .base_next_o(base_next)
  );

  ldst_ctrl ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .word_i (word),
    .cap_o  (cap),
    .lo_o   (lo),
    .hi_o   (hi),
    .done_o (done)
  );

  ldst_bytes #(.DW(DW), .BW(BW)) bytes_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cap),
    .lo_rd_i  (lo && !store_q),
    .hi_rd_i  (hi && !store_q),
    .hi_i     (hi),
    .rdata_i  (mem_rdata_i),
    .sdata_i  (sdata_q),
    .wdata_o  (mem_wdata_o),
    .ld_data_o(ld_data_o)
  );

  assign xfer         = lo || hi;
  assign mem_addr_o   = hi ? ea + AW'(1) : ea;
  assign mem_re_o     = xfer && !store_q;
  assign mem_we_o     = xfer && store_q;
  assign base_we_o    = base_upd && (store_q ? done : lo);
  assign base_wdata_o = base_next;
  assign ld_we_o      = done && !store_q;
  assign done_o       = done;

  a_r6_hi_addr_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi |-> mem_addr_o == $past(mem_addr_o) + AW'(1));
  a_r7_byte_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_we_o && !$past(hi)) |-> ld_data_o[DW-1:BW] == '0);
  a_r4_load_base_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_o && mem_re_o) |-> !$past(mem_re_o));
  a_r5_store_base_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_o && !mem_re_o) |-> done_o);
  a_r10_ld_we_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_we_o |-> done_o);
  a_r10_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
endmodule

// File: tb/ldst_unit_tb.sv
`timescale 1ns/1ps
module ldst_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start, store, size_word, stack;
  logic [1:0]  mode;
  logic [7:0]  slot;
  logic [5:0]  off;
  logic [15:0] sdata, ind, base;
  logic        base_we, mem_re, mem_we, ld_we, done;
  logic [15:0] base_wdata, mem_addr, ld_data;
  logic [7:0]  mem_wdata, mem_rdata;
  int          checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  ldst_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .store_i(store),
    .mode_i(mode), .slot_i(slot), .off_i(off), .size_word_i(size_word),
    .stack_i(stack), .sdata_i(sdata), .ind_i(ind), .base_i(base),
    .base_we_o(base_we), .base_wdata_o(base_wdata), .mem_addr_o(mem_addr),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .ld_we_o(ld_we), .ld_data_o(ld_data), .done_o(done)
  );

  function automatic logic [7:0] mem_fn(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  always_comb mem_rdata = mem_fn(mem_addr);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] bsel(int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h1234;
      default: return 16'h8000;
    endcase
  endfunction

  function automatic logic [5:0] osel(int i);
    case (i)
      0: return 6'd0;
      1: return 6'd1;
      2: return 6'h3F;
      3: return 6'd31;
      default: return 6'h20;
    endcase
  endfunction

  // called just after a negedge with the unit idle or in its done cycle
  task automatic run_op(input logic st, input logic [1:0] md, input logic [7:0] sl,
                        input logic [5:0] of, input logic sw, input logic sk,
                        input logic [15:0] dat, input logic [15:0] bas,
                        input logic [15:0] ix, input logic poke);
    logic        ext, is_word, bupd;
    logic [15:0] sz, eb, ea, bexp, ldexp;
    logic [16:0] wide;
    logic [15:0] xa [4];
    logic        xw [4];
    logic [7:0]  xd [4];
    int          nx, nbw, bw_cyc, done_cyc, ld_cnt;
    logic [15:0] bw_val, ld_val;
    string       atag, btag;

    ext     = md[1];
    is_word = !ext || sw;
    sz      = is_word ? 16'd2 : 16'd1;
    bupd    = ext && sk;
    eb      = (bupd && !st) ? bas - sz : bas;
    ea      = md == 2'b00 ? {sl[6:0], 1'b0} + {7'd0, sl[7], 8'd0} * 16'd0 + (16'(sl) << 1) - {sl[6:0], 1'b0}
            : md == 2'b01 ? ix : eb + {{10{of[5]}}, of};
    ldexp   = is_word ? {mem_fn(ea + 16'd1), mem_fn(ea)} : {8'h00, mem_fn(ea)};
    bexp    = st ? bas + sz : bas - sz;
    wide    = st ? {1'b0, bas} + {1'b0, sz} : {1'b0, bas} - {1'b0, sz};
    atag    = md == 2'b00 ? "R1 addr" : md == 2'b01 ? "R2 addr" : "R3 addr";
    btag    = wide[16] ? "R9 base wrap" : (st ? "R5 base" : "R4 base");

    start = 1'b1; store = st; mode = md; slot = sl; off = of;
    size_word = sw; stack = sk; sdata = dat; base = bas; ind = ix;
    nx = 0; nbw = 0; bw_cyc = 0; done_cyc = 0; ld_cnt = 0;
    bw_val = '0; ld_val = '0;
    for (int i = 0; i < 4; i++) begin xa[i] = '0; xw[i] = 1'b0; xd[i] = '0; end
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      if (mem_re || mem_we) begin
        if (nx < 4) begin xa[nx] = mem_addr; xw[nx] = mem_we; xd[nx] = mem_wdata; end
        nx++;
      end
      if (base_we) begin nbw++; bw_cyc = c; bw_val = base_wdata; end
      if (ld_we) begin ld_cnt++; ld_val = ld_data; end
      if (done && done_cyc == 0) done_cyc = c;
      // stray command in the first transfer cycle must be ignored (R11)
      if (c == 1 && poke) begin
        start = 1'b1; store = ~st; mode = ~md; slot = ~sl; off = ~of;
        size_word = ~sw; stack = ~sk; sdata = ~dat; base = ~bas; ind = ~ix;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end

    chk(nx == int'(sz), is_word ? "R6 transfer count" : "R7 transfer count", nx, sz);
    chk(xa[0] == ea, atag, xa[0], ea);
    if (is_word) chk(xa[1] == ea + 16'd1, "R6 high addr", xa[1], ea + 16'd1);
    for (int k = 0; k < 2; k++)
      if (k < int'(sz)) chk(xw[k] == st, "R10 direction", xw[k], st);
    if (st) begin
      chk(xd[0] == dat[7:0], is_word ? "R6 low byte" : "R7 byte store", xd[0], dat[7:0]);
      if (is_word) chk(xd[1] == dat[15:8], "R6 high byte", xd[1], dat[15:8]);
      chk(ld_cnt == 0, "R10 store no ld_we", ld_cnt, 0);
    end else begin
      chk(ld_cnt == 1, "R8 ld_we once", ld_cnt, 1);
      chk(ld_val == ldexp, is_word ? "R6 load word" : "R7 byte zext", ld_val, ldexp);
    end
    chk(done_cyc == int'(sz) + 1, poke ? "R11 done cycle" : "R8 done cycle", done_cyc, sz + 16'd1);
    if (bupd) begin
      chk(nbw == 1, st ? "R5 base we" : "R4 base we", nbw, 1);
      chk(bw_cyc == (st ? int'(sz) + 1 : 1), st ? "R5 base cycle" : "R4 base cycle",
          bw_cyc, st ? sz + 16'd1 : 16'd1);
      chk(bw_val == bexp, btag, bw_val, bexp);
    end else begin
      chk(nbw == 0, "R10 no base write", nbw, 0);
    end
  endtask

  initial begin
    int n;
    start = 0; store = 0; mode = 0; slot = 0; off = 0; size_word = 0;
    stack = 0; sdata = 0; ind = 0; base = 0;
    repeat (3) @(negedge clk);
    chk({mem_re, mem_we, base_we, ld_we, done} == 5'b0, "R12 reset strobes",
        {mem_re, mem_we, base_we, ld_we, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_re, mem_we, base_we, ld_we, done} == 5'b0, "R12 idle strobes",
        {mem_re, mem_we, base_we, ld_we, done}, 0);
    n = 0;
    for (int st = 0; st < 2; st++)
      for (int md = 0; md < 4; md++)
        for (int sw = 0; sw < 2; sw++)
          for (int sk = 0; sk < 2; sk++)
            for (int bi = 0; bi < 5; bi++)
              for (int oi = 0; oi < 5; oi++) begin
                logic [15:0] b;
                b = bsel(bi);
                run_op(st[0], md[1:0], 8'(bi * 61 + oi * 7 + (oi == 4 ? 200 : 0)),
                       osel(oi), sw[0], sk[0], b ^ 16'hC3A7 ^ 16'(oi * 4099),
                       b, b ^ 16'hFFFF, n[0]);
                n++;
              end
    @(negedge clk);
    chk({mem_re, mem_we, done} == 3'b0, "R8 idle after done", {mem_re, mem_we, done}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule